// File: doc/BRIEF.md
# Multiply-Accumulate/Subtract Unit

This block is a 64-bit integer multiply-accumulate unit. A request carries an opcode and three operands: the current destination value, which serves as the accumulator, and two sources. The unit multiplies the two sources and adds the product to the accumulator or subtracts it. Only the low 64 bits of the product are kept. The result is produced at one of three widths: the full 64 bits, a 32-bit word sign-extended to 64 bits, or a halfword form. In the halfword form the low 16 bits of each source are sign-extended before the multiply, and the 32-bit result is sign-extended.

The multiplier is iterative. It retires `STEP` multiplier bits per cycle, so one operation takes `XLEN/STEP` multiply cycles plus one cycle to format the result. Requests use a valid/ready handshake. Only one operation is in flight at a time. Completion is marked by a single-cycle done pulse, and the result stays on its port until the next completion replaces it.

Top module: `mac_unit`

## Requirements
- R1: After reset `req_ready` is 1, `res_done` is 0 and `res_data` is 0.
- R2: Opcode bit 2 = 0 with width field `req_op[1:0]` = 00 (full): the result is acc + src1*src2, modulo 2^64.
- R3: Opcode bit 2 = 1 selects subtraction: with width 00 the result is acc − src1*src2, modulo 2^64.
- R4: Width 01 (word): the full-width sum or difference is computed, then bit 31 is sign-extended into bits 63:32.
- R5: Width 10 (halfword): src1[15:0] and src2[15:0] are each sign-extended before the multiply. The upper source bits have no effect. The result is the sign-extended low 32 bits of acc ± product.
- R6: Width 11 behaves exactly like width 00, for both add and subtract.
- R7: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `res_done` is 1 for exactly one cycle, XLEN/STEP+1 clock edges after the accepting edge.
- R8: `req_ready` is 0 from the edge after acceptance until the done cycle, and is 1 in the done cycle. A request presented while `req_ready` is 0 is ignored: it does not change the pending result.
- R9: `res_data` changes only at the edge that raises `res_done` and is held stable otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_op | input | 3 | Bit 2 subtract; bits 1:0 width (00 full, 01 word, 10 half, 11 full) |
| req_acc | input | XLEN | Accumulator (current destination value) |
| req_src1 | input | XLEN | First multiplicand |
| req_src2 | input | XLEN | Second multiplicand |
| res_data | output | XLEN | Result, held between completions |
| res_done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with XLEN=64 and STEP=16. This gives four multiply iterations and a five-edge latency. Requests therefore complete quickly, and the run has room for back-to-back acceptance in the done cycle and for junk requests held during a busy window. The 16-bit step makes each partial product span a full halfword. As a result, the sign-extended negative halfwords and the 64-bit wraparound cases exercise carries across several iteration boundaries.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [1:0] {
        MW_FULL = 2'b00,
        MW_WORD = 2'b01,
        MW_HALF = 2'b10,
        MW_ALT  = 2'b11
    } mac_width_e;

    typedef struct packed {
        logic       sub;
        mac_width_e width;
    } mac_op_t;
endpackage

// File: rtl/mac_opnd_prep.sv
module mac_opnd_prep
    import mac_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  mac_width_e        width,
    input  logic [XLEN-1:0]   src1,
    input  logic [XLEN-1:0]   src2,
    output logic [XLEN-1:0]   mul_a,
    output logic [XLEN-1:0]   mul_b
);
    localparam int HW = 16;

    always_comb begin
        if (width == MW_HALF) begin
            mul_a = {{(XLEN-HW){src1[HW-1]}}, src1[HW-1:0]};
            mul_b = {{(XLEN-HW){src2[HW-1]}}, src2[HW-1:0]};
        end else begin
            mul_a = src1;
            mul_b = src2;
        end
    end
endmodule

// File: rtl/mac_iter_mul.sv
module mac_iter_mul #(
    parameter int XLEN = 64,
    parameter int STEP = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic            fin,
    output logic [XLEN-1:0] prod
);
    localparam int ITER = XLEN / STEP;
    localparam int CW   = $clog2(ITER + 1);

    typedef struct packed {
        logic            run;
        logic            fin;
        logic [CW-1:0]   cnt;
        logic [XLEN-1:0] mcand;
        logic [XLEN-1:0] mplier;
        logic [XLEN-1:0] prod;
    } mul_st_t;

    mul_st_t st_d, st_q;
    logic [XLEN-1:0] pp;

    always_comb begin
        st_d     = st_q;
        st_d.fin = 1'b0;
        pp       = st_q.mcand * XLEN'(st_q.mplier[STEP-1:0]);
        if (start) begin
            st_d.run    = 1'b1;
            st_d.cnt    = CW'(ITER);
            st_d.mcand  = opa;
            st_d.mplier = opb;
            st_d.prod   = '0;
        end else if (st_q.run) begin
            st_d.prod   = st_q.prod + pp;
            st_d.mcand  = st_q.mcand << STEP;
            st_d.mplier = st_q.mplier >> STEP;
            st_d.cnt    = st_q.cnt - 1'b1;
            if (st_q.cnt == CW'(1)) begin
                st_d.run = 1'b0;
                st_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fin  = st_q.fin;
    assign prod = st_q.prod;

    // R7: completion from the multiplier lasts one cycle
    a_r7_fin_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fin |=> !st_q.fin);
    // R8: no new operand load while iterating
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !st_q.run);
endmodule

// File: rtl/mac_result_fmt.sv
module mac_result_fmt
    import mac_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  mac_op_t         op,
    input  logic [XLEN-1:0] acc,
    input  logic [XLEN-1:0] prod,
    output logic [XLEN-1:0] res
);
    localparam int WW = 32;
    logic [XLEN-1:0] raw;

    always_comb begin
        raw = op.sub ? (acc - prod) : (acc + prod);
        if (op.width == MW_WORD || op.width == MW_HALF)
            res = {{(XLEN-WW){raw[WW-1]}}, raw[WW-1:0]};
        else
            res = raw;
    end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int STEP = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [2:0]      req_op,
    input  logic [XLEN-1:0] req_acc,
    input  logic [XLEN-1:0] req_src1,
    input  logic [XLEN-1:0] req_src2,
    output logic [XLEN-1:0] res_data,
    output logic            res_done
);
    typedef struct packed {
        logic            busy;
        logic            done;
        mac_op_t         op;
        logic [XLEN-1:0] acc;
        logic [XLEN-1:0] res;
    } top_st_t;

    top_st_t st_d, st_q;
    mac_op_t req_op_t;
    logic    accept;
    logic    mul_fin;
    logic [XLEN-1:0] mul_a, mul_b, mul_prod, fmt_res;

    assign req_op_t = mac_op_t'(req_op);
    assign accept   = req_valid && !st_q.busy;

    mac_opnd_prep #(.XLEN(XLEN)) i_prep (
        .width (req_op_t.width),
        .src1  (req_src1),
        .src2  (req_src2),
        .mul_a (mul_a),
        .mul_b (mul_b)
    );

    mac_iter_mul #(.XLEN(XLEN), .STEP(STEP)) i_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .opa   (mul_a),
        .opb   (mul_b),
        .fin   (mul_fin),
        .prod  (mul_prod)
    );

    mac_result_fmt #(.XLEN(XLEN)) i_fmt (
        .op   (st_q.op),
        .acc  (st_q.acc),
        .prod (mul_prod),
        .res  (fmt_res)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.op   = req_op_t;
            st_d.acc  = req_acc;
        end else if (st_q.busy && mul_fin) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.res  = fmt_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready = !st_q.busy;
    assign res_data  = st_q.res;
    assign res_done  = st_q.done;

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |=> !res_done);
    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    a_r8_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |-> req_ready);
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !res_done |-> $stable(res_data));
    a_r4_narrow_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && (st_q.op.width == MW_WORD || st_q.op.width == MW_HALF))
        |-> (res_data[XLEN-1:32] == {(XLEN-32){res_data[31]}}));
endmodule

// File: tb/test_mac_unit.sv
module test_mac_unit;
    localparam int XLEN = 64;
    localparam int STEP = 16;
    localparam int LAT  = XLEN / STEP + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [2:0] req_op = '0;
    logic [XLEN-1:0] req_acc = '0, req_src1 = '0, req_src2 = '0;
    logic [XLEN-1:0] res_data;
    logic res_done;

    int n_tests = 0;
    int n_fail  = 0;
    bit mon_on  = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mac_unit #(.XLEN(XLEN), .STEP(STEP)) i_mac_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_acc(req_acc), .req_src1(req_src1),
        .req_src2(req_src2), .res_data(res_data), .res_done(res_done)
    );

    task automatic chk(input bit ok, input string tag, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [XLEN-1:0] ref_calc(input logic [2:0] op,
        input logic [XLEN-1:0] c, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
        logic [XLEN-1:0] x, y, p, s;
        x = a; y = b;
        if (op[1:0] == 2'b10) begin
            x = {{48{a[15]}}, a[15:0]};
            y = {{48{b[15]}}, b[15:0]};
        end
        p = x * y;
        s = op[2] ? c - p : c + p;
        if (op[1:0] == 2'b01 || op[1:0] == 2'b10) s = {{32{s[31]}}, s[31:0]};
        return s;
    endfunction

    function automatic string ref_tag(input logic [2:0] op);
        case (op[1:0])
            2'b01: return "R4 word";
            2'b10: return "R5 half";
            2'b11: return "R6 alt-full";
            default: return op[2] ? "R3 full-sub" : "R2 full-add";
        endcase
    endfunction

    // cycle-by-cycle reference model
    bit m_busy = 0, m_done = 0;
    int m_cnt = 0;
    logic [XLEN-1:0] m_res = '0, m_pend = '0;
    string m_tag = "R1", m_ptag = "R1";

    always @(negedge clk) begin
        if (mon_on) begin
            chk(req_ready == !m_busy, "R8 ready", XLEN'(req_ready), XLEN'(!m_busy));
            chk(res_done == m_done, "R7 done timing", XLEN'(res_done), XLEN'(m_done));
            chk(res_data == m_res, (m_done ? m_tag : "R9 hold"), res_data, m_res);
            m_done = 0;
            if (m_busy) begin
                if (m_cnt == 1) begin
                    m_busy = 0; m_done = 1; m_res = m_pend; m_tag = m_ptag;
                end else m_cnt--;
            end else if (req_valid) begin
                m_busy = 1; m_cnt = LAT;
                m_pend = ref_calc(req_op, req_acc, req_src1, req_src2);
                m_ptag = ref_tag(req_op);
            end
        end
    end

    task automatic issue(input logic [2:0] op, input logic [XLEN-1:0] c,
                         input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
        @(posedge clk); #1;
        req_valid = 1; req_op = op; req_acc = c; req_src1 = a; req_src2 = b;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!req_ready || res_done) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", XLEN'(req_ready), 1);
        chk(res_done == 1'b0, "R1 done", XLEN'(res_done), 0);
        chk(res_data == '0, "R1 data", res_data, 0);
        mon_on = 1;

        issue(3'b000, 64'd10, 64'd6, 64'd7);                      // R2
        wait_idle();
        issue(3'b000, 64'hFFFF_FFFF_FFFF_FFF0, 64'h1_0000_0001, 64'h1_0000_0003); // R2 wrap
        wait_idle();
        issue(3'b100, 64'd5, 64'd3, 64'd4);                       // R3 negative result
        wait_idle();
        issue(3'b100, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2); // R3
        wait_idle();
        issue(3'b001, 64'h7FFF_FFFF, 64'd1, 64'd1);               // R4 overflow to neg
        wait_idle();
        issue(3'b101, 64'hAAAA_0000_0000_0010, 64'd3, 64'd2);     // R4 sub
        wait_idle();
        issue(3'b010, 64'd100, 64'hDEAD_BEEF_0000_FFFE, 64'h1234_0000_0000_0003); // R5
        wait_idle();
        issue(3'b110, 64'd0, 64'h8000, 64'h8000);                 // R5 min*min
        wait_idle();
        issue(3'b011, 64'd1, 64'h1_0000_0000, 64'h2_0000_0000);   // R6
        wait_idle();
        issue(3'b111, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF); // R6 sub
        wait_idle();

        // R8: junk request while busy is ignored
        issue(3'b000, 64'd1, 64'd2, 64'd3);
        req_valid = 1; req_op = 3'b100; req_acc = 64'hFF; req_src1 = 64'h55; req_src2 = 64'h77;
        repeat (2) @(posedge clk);
        #1 req_valid = 0;
        wait_idle();

        // R7/R8: back-to-back acceptance in the done cycle
        issue(3'b001, 64'd9, 64'hFFFF_FFFF, 64'd2);
        issue(3'b010, 64'd9, 64'hFFFF, 64'hFFFF);
        wait_idle();
        repeat (4) @(posedge clk);                                // R9 idle hold
        finished = 1;
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule